// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two tri-state buses, called A and B, through a set of independent byte-wide lanes. Each lane has two storage registers, one per direction, and each register has its own capture clock. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. A capture happens on every rising edge of that register's clock, whatever the select and enable inputs are doing.

Each direction has a select input. The select decides whether the driven bus carries live data from the opposite bus or the contents of that direction's register. Each direction also has an enable that gates its bus driver. The B-side enable is active high and the A-side enable is active low, so with both enables at their idle levels the lane isolates the two buses. An active-low asynchronous reset clears every register. The reset does not enable any driver.

A typical use is a bus bridge that either forwards traffic straight through or parks a snapshot of one bus and presents it later on the other. It can also take the value it presents on one bus and copy it back into the register of the opposite direction.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Lanes are independent. Lane n occupies bits [8n+7:8n] of both buses and is controlled only by bit n of every control input. Clock edges and control changes on one lane never alter the registers or bus values of another lane.
- R2: A lane drives its B slice only while its oe_ab bit is 1. It drives its A slice only while its oe_ba_n bit is 0. With oe_ab=0 and oe_ba_n=1 the lane leaves both slices undriven.
- R3: While the B slice is driven, sel_ab=0 places the live A slice value on it and sel_ab=1 places the A-to-B register on it.
- R4: While the A slice is driven, sel_ba=0 places the live B slice value on it and sel_ba=1 places the B-to-A register on it.
- R5: A rising edge of clk_ab loads the A slice value into the A-to-B register, whatever the levels of oe_ab, oe_ba_n, sel_ab and sel_ba.
- R6: A rising edge of clk_ba loads the B slice value into the B-to-A register, whatever the levels of oe_ab, oe_ba_n, sel_ab and sel_ba.
- R7: With oe_ab=1 and sel_ab=1, a clk_ba edge copies the stored A-to-B value into the B-to-A register, so both registers then hold the same A data.
- R8: A low rst_n clears both registers of every lane to zero at once, holds them there against clock edges, and enables no bus driver.
- R9: When the live value and the stored value of a direction are equal, toggling that direction's select leaves the driven bus value unchanged.
- R10: Rules R1 to R6 hold in every combination of oe_ab, oe_ba_n, sel_ab and sel_ba, except both directions enabled with both selects live. That combination forms a feedback loop whose bus value is set by what was there before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bus | inout | LANES*LANE_W | A side bus, lane n in bits [8n+7:8n] |
| b_bus | inout | LANES*LANE_W | B side bus, lane n in bits [8n+7:8n] |
| oe_ab | input | LANES | Per-lane enable for driving B, active high |
| oe_ba_n | input | LANES | Per-lane enable for driving A, active low |
| clk_ab | input | LANES | Per-lane capture clock of the A-to-B register |
| clk_ba | input | LANES | Per-lane capture clock of the B-to-A register |
| sel_ab | input | LANES | Per-lane B source: 0 live A, 1 stored |
| sel_ba | input | LANES | Per-lane A source: 0 live B, 1 stored |
| rst_n | input | 1 | Asynchronous reset of all registers, active low |

## Verification
The hardest case to reach is the register-to-register copy of R7. The lane must drive B from its own A-to-B register while nothing else drives B. The B-to-A clock is then pulsed, and the result can only be seen after the lane turns around to drive A from the stored copy with the A side released. The bench gets there with a scripted sequence: load the A-to-B register, present it on B, pulse the opposite clock, release and re-enable, then read A. Undriven slices fall to zero through weak pull-downs on the bench side. A zero read with a nonzero register therefore proves isolation, and the register sweep uses distinct nonzero values per lane so every source is told apart.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  inout  wire  [LANES*LANE_W-1:0] a_bus,
  inout  wire  [LANES*LANE_W-1:0] b_bus,
  input  logic [LANES-1:0]        oe_ab,
  input  logic [LANES-1:0]        oe_ba_n,
  input  logic [LANES-1:0]        clk_ab,
  input  logic [LANES-1:0]        clk_ba,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  input  logic                    rst_n
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ab_q, ba_q;
    logic [LANE_W-1:0] a_in, b_in;
    logic [LANE_W-1:0] a_src, b_src;

    assign a_in = a_bus[g*LANE_W +: LANE_W];
    assign b_in = b_bus[g*LANE_W +: LANE_W];

    always_ff @(posedge clk_ab[g] or negedge rst_n)
      if (!rst_n) ab_q <= '0;
      else        ab_q <= a_in;

    always_ff @(posedge clk_ba[g] or negedge rst_n)
      if (!rst_n) ba_q <= '0;
      else        ba_q <= b_in;

    assign b_src = sel_ab[g] ? ab_q : a_in;
    assign a_src = sel_ba[g] ? ba_q : b_in;

    assign b_bus[g*LANE_W +: LANE_W] = oe_ab[g]   ? b_src : {LANE_W{1'bz}};
    assign a_bus[g*LANE_W +: LANE_W] = !oe_ba_n[g] ? a_src : {LANE_W{1'bz}};

    AST_AB_RESET_HELD: assert property (@(posedge clk_ab[g])
      !rst_n |-> ab_q == '0); // R8
    AST_BA_RESET_HELD: assert property (@(posedge clk_ba[g])
      !rst_n |-> ba_q == '0); // R8
    AST_B_SHOWS_STORED: assert property (@(negedge clk_ab[g]) disable iff (!rst_n)
      (oe_ab[g] && sel_ab[g]) |-> b_in == ab_q); // R3
    AST_A_SHOWS_STORED: assert property (@(negedge clk_ba[g]) disable iff (!rst_n)
      (!oe_ba_n[g] && sel_ba[g]) |-> a_in == ba_q); // R4
  end

endmodule

// File: tb/sim_reg_bus_xcvr.sv
module sim_reg_bus_xcvr;
  localparam int LANES = 2;
  localparam int W = 8;
  localparam int BW = LANES * W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  wire  [BW-1:0] a_bus, b_bus;
  logic [BW-1:0] a_drv = '0, b_drv = '0, a_en = '0, b_en = '0;
  logic [LANES-1:0] oe_ab = '0, oe_ba_n = '1, clk_ab = '0, clk_ba = '0;
  logic [LANES-1:0] sel_ab = '0, sel_ba = '0;
  logic rst_n = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  for (genvar k = 0; k < BW; k++) begin : g_ext
    assign a_bus[k] = a_en[k] ? a_drv[k] : 1'bz;
    assign b_bus[k] = b_en[k] ? b_drv[k] : 1'bz;
    pulldown (a_bus[k]);
    pulldown (b_bus[k]);
  end

  reg_bus_xcvr #(.LANES(LANES), .LANE_W(W)) u0 (
    .a_bus(a_bus), .b_bus(b_bus), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .rst_n(rst_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_a(input int l, input logic [W-1:0] v);
    a_drv[l*W +: W] = v; a_en[l*W +: W] = '1;
  endtask
  task automatic drive_b(input int l, input logic [W-1:0] v);
    b_drv[l*W +: W] = v; b_en[l*W +: W] = '1;
  endtask
  task automatic release_all();
    a_en = '0; b_en = '0;
  endtask
  task automatic isolate();
    oe_ab = '0; oe_ba_n = '1; sel_ab = '0; sel_ba = '0;
  endtask
  task automatic pulse_ab(input int l);
    #1 clk_ab[l] = 1'b1; #2 clk_ab[l] = 1'b0; #1;
  endtask
  task automatic pulse_ba(input int l);
    #1 clk_ba[l] = 1'b1; #2 clk_ba[l] = 1'b0; #1;
  endtask
  function automatic logic [W-1:0] a_of(input int l);
    return a_bus[l*W +: W];
  endfunction
  function automatic logic [W-1:0] b_of(input int l);
    return b_bus[l*W +: W];
  endfunction

  task automatic load(input int l, input logic [W-1:0] abv, input logic [W-1:0] bav);
    isolate(); release_all();
    drive_a(l, abv); pulse_ab(l);
    drive_b(l, bav); pulse_ba(l);
    release_all(); #2;
  endtask

  task automatic sweep(input int l, input logic [W-1:0] abv, input logic [W-1:0] bav);
    logic [W-1:0] ax, bx, ea, eb;
    int o;
    o = 1 - l;
    ax = 8'h0F ^ abv; bx = 8'hF0 ^ bav;
    load(l, abv, bav);
    for (int c = 0; c < 16; c++) begin
      logic oa, obn, sa, sb;
      oa = c[0]; obn = c[1]; sa = c[2]; sb = c[3];
      if (oa && !obn && !sa && !sb) continue;
      isolate(); release_all();
      oe_ab[l] = oa; oe_ba_n[l] = obn; sel_ab[l] = sa; sel_ba[l] = sb;
      if (obn) drive_a(l, ax);
      if (!oa) drive_b(l, bx);
      ea = ax; eb = bx;
      if (oa && !obn) begin
        if (sa) begin eb = abv; ea = sb ? bav : eb; end
        else    begin ea = bav; eb = ea; end
      end else if (oa) eb = sa ? abv : ax;
      else if (!obn) ea = sb ? bav : bx;
      #2;
      chk("R10 sweep A", a_of(l), ea);
      chk("R10 sweep B", b_of(l), eb);
      chk("R1 other lane A idle", a_of(o), 8'h00);
      chk("R1 other lane B idle", b_of(o), 8'h00);
      #2;
    end
    isolate(); release_all(); #2;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #10;
    // R8: clock edge under reset leaves the register at zero
    drive_a(0, 8'h5A); pulse_ab(0); release_all();
    oe_ab[0] = 1'b1; sel_ab[0] = 1'b1; #2;
    chk("R8 reset holds A-to-B reg", b_of(0), 8'h00);
    isolate(); #2;
    chk("R8 reset drives no A", a_of(0), 8'h00);
    rst_n = 1'b1; #4;

    // R8/R3: after reset the stored zero shows instead of live A
    drive_a(0, 8'hFF); oe_ab[0] = 1'b1; sel_ab[0] = 1'b1; #2;
    chk("R8 stored zero after reset", b_of(0), 8'h00);
    sel_ab[0] = 1'b0; #2;
    chk("R3 live A to B", b_of(0), 8'hFF);

    // R5: capture with driver enabled and stored select
    sel_ab[0] = 1'b1; drive_a(0, 8'h3C); pulse_ab(0); #1;
    chk("R5 capture while enabled", b_of(0), 8'h3C);
    // R5: capture while isolated
    isolate(); drive_a(0, 8'hC3); pulse_ab(0); release_all();
    oe_ab[0] = 1'b1; sel_ab[0] = 1'b1; #2;
    chk("R5 capture while isolated", b_of(0), 8'hC3);

    // R7: stored A on B copied into B-to-A register
    pulse_ba(0);
    isolate(); #2;
    chk("R2 isolated B undriven", b_of(0), 8'h00);
    chk("R2 isolated A undriven", a_of(0), 8'h00);
    oe_ba_n[0] = 1'b0; sel_ba[0] = 1'b1; #2;
    chk("R7 both registers hold A data", a_of(0), 8'hC3);

    // R6 and R4: capture B with A driver on and stored select
    isolate(); oe_ba_n[0] = 1'b0; sel_ba[0] = 1'b1;
    drive_b(0, 8'h81); pulse_ba(0); #1;
    chk("R6 capture while enabled", a_of(0), 8'h81);
    sel_ba[0] = 1'b0; drive_b(0, 8'h42); #2;
    chk("R4 live B to A", a_of(0), 8'h42);
    isolate(); release_all(); #2;

    // R9: equal live and stored values through a select toggle
    drive_a(0, 8'h66); pulse_ab(0);
    oe_ab[0] = 1'b1; sel_ab[0] = 1'b0; #2;
    chk("R9 live equal", b_of(0), 8'h66);
    sel_ab[0] = 1'b1; #2;
    chk("R9 stored equal", b_of(0), 8'h66);
    sel_ab[0] = 1'b0; #2;
    chk("R9 back to live", b_of(0), 8'h66);
    isolate(); release_all(); #2;

    // R1: lane 1 activity leaves lane 0 registers alone
    load(0, 8'hAA, 8'h55);
    load(1, 8'h11, 8'h22);
    oe_ab = '1; sel_ab = '1; oe_ba_n = '0; sel_ba = '1; #2;
    chk("R1 lane0 A-to-B kept", b_of(0), 8'hAA);
    chk("R1 lane0 B-to-A kept", a_of(0), 8'h55);
    chk("R1 lane1 A-to-B", b_of(1), 8'h11);
    chk("R1 lane1 B-to-A", a_of(1), 8'h22);
    isolate(); #2;

    sweep(0, 8'hA6, 8'h5B);
    sweep(1, 8'h39, 8'hC4);

    // R8: reset in mid-run clears and enables nothing
    load(0, 8'h77, 8'h88);
    rst_n = 1'b0; #2;
    chk("R8 reset no B drive", b_of(0), 8'h00);
    chk("R8 reset no A drive", a_of(0), 8'h00);
    oe_ab[0] = 1'b1; sel_ab[0] = 1'b1; oe_ba_n[0] = 1'b0; sel_ba[0] = 1'b1; #2;
    chk("R8 A-to-B cleared", b_of(0), 8'h00);
    chk("R8 B-to-A cleared", a_of(0), 8'h00);
    isolate(); rst_n = 1'b1; #4;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule